// File: doc/BRIEF.md
# Strobe-Sequenced Scratchpad Memory

This block is a small scratchpad of 64 words of 4 bits. It is built from four banks of 16 words each. An internal address counter picks the word. The counter either steps upward by one or takes a parallel value, and a mode input chooses which. The two upper address bits pick one bank. The four lower bits address a word inside every bank at the same time.

A single strobe input paces the whole block. Its rising edge does three things:
- it moves the address counter on;
- it freezes the output latch;
- it ends any write.

While the strobe is LOW in write mode, an active-low write enable is asserted for the selected bank. The word at the current address then takes the data input. In read mode the write enable stays HIGH. While the strobe is LOW the output latch follows the addressed word. From the rising edge onward it holds that word, and it keeps holding it until the strobe next goes LOW.

The strobe and all the other inputs are sampled on the system clock. "LOW phase" therefore means the clock cycles in which the sampled strobe is 0. The banks are modelled as synchronous arrays with a combinational read.

Top module: `strobe_scratchpad`

## Requirements
- R1: A synchronous active-low reset sets the address to 0 and clears the output to 0. Memory contents are kept through reset. While reset is held, a HIGH strobe produces no rising edge.
- R2: In count mode (`load_mode`=0) each rising edge of the strobe adds one to the address. Address 63 wraps to 0.
- R3: In load mode (`load_mode`=1) a rising edge of the strobe sets the address to `load_addr`.
- R4: In write mode (`wr_mode`=1), for each clock cycle the strobe is LOW, `din` is stored at the address the counter holds during that LOW phase. The address changes only at the rising edge that follows.
- R5: In read mode (`wr_mode`=0) no word is written, whatever the strobe and `din` do.
- R6: While the strobe is LOW, `dout` takes the addressed word one clock later. From the rising edge it holds that value until the strobe is next LOW.
- R7: Address bits [5:4] select the bank (0 to 3) and bits [3:0] select the word. Words that share their low bits but sit in different banks are independent.
- R8: When `din` changes during a LOW phase, the word keeps the value that was present in the last LOW cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | Shared strobe: rising edge steps or loads the address and freezes the latch; LOW is the write phase |
| wr_mode | input | 1 | 1 = write mode, 0 = read mode |
| load_mode | input | 1 | 1 = load `load_addr` at the rising edge, 0 = count up |
| load_addr | input | 6 | Parallel address value |
| din | input | 4 | Write data |
| dout | output | 4 | Latched read data |

## Verification
Three things fall on the same strobe rising edge: the address counter moves (by stepping or by loading), the output latch freezes, and the write pulse ends. A fault in their ordering would move the address before the last write or before the latch closes. The bench drives back-to-back strobe cycles with load and count mixed in. It also changes `din` inside a LOW phase. It then reads each word back and checks it against a reference model of the memory and the address. The output is also compared in every HIGH cycle after an edge, so a latch that opens too early or captures the next address shows up as a mismatch.

// File: rtl/sp_pkg.sv
// Shared sizes and types for the strobe-sequenced scratchpad.
// Assumes the bank count and bank depth are powers of two.
package sp_pkg;
    parameter int WORD_W     = 4;
    parameter int BANK_DEPTH = 16;
    parameter int BANKS      = 4;
    localparam int LOW_W  = $clog2(BANK_DEPTH);
    localparam int SEL_W  = $clog2(BANKS);
    localparam int ADDR_W = LOW_W + SEL_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sp_addr_counter.sv
// Address counter stepped or loaded on the strobe's rising edge.
// Assumes the strobe is synchronous to clk; reset holds the edge detector
// in the "was high" state so that a high strobe after reset is not an edge.
module sp_addr_counter #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              load_mode,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              rise
);
    logic strobe_q;

    assign rise = strobe & ~strobe_q;

    // Remember last strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe;
    end

    // Step or load the address on a strobe rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)         addr <= '0;
        else if (rise) begin
            if (load_mode)  addr <= load_addr;
            else            addr <= addr + 1'b1;
        end
    end

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(addr));
    // R3
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && load_mode) |=> (addr == $past(load_addr)));
endmodule

// File: rtl/sp_bank.sv
// One bank of the scratchpad: synchronous write, combinational read.
// Assumes we is already qualified by the bank select; contents are not reset.
module sp_bank #(
    parameter int WORD_W = 4,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] a,
    input  logic [WORD_W-1:0]        d,
    output logic [WORD_W-1:0]        q
);
    logic [WORD_W-1:0] cells [DEPTH];

    // Store the data word while the write is active
    always_ff @(posedge clk) begin
        if (we) cells[a] <= d;
    end

    assign q = cells[a];
endmodule

// File: rtl/sp_out_latch.sv
// Output latch modelled on clk: follows d while en_n is low, holds otherwise.
// Assumes en_n is the sampled strobe level.
module sp_out_latch #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // Track the input while open, freeze while closed
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (!en_n) q <= d;
    end

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(q));
endmodule

// File: rtl/strobe_scratchpad.sv
// Top level: counter-addressed scratchpad of BANKS banks of BANK_DEPTH words.
// The upper address bits are decoded into bank selects, and the addressed
// bank's word feeds the output latch. A single strobe paces the counter, the
// latch and the active-low write enable.
// Assumes the strobe is synchronous to clk.
module strobe_scratchpad
    import sp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe,
    input  logic        wr_mode,
    input  logic        load_mode,
    input  logic [5:0]  load_addr,
    input  logic [3:0]  din,
    output logic [3:0]  dout
);
    addr_t             addr;
    logic              rise;
    logic              we_n;
    logic [BANKS-1:0]  bank_sel;
    logic [BANKS-1:0]  bank_we;
    word_t             bank_q [BANKS];
    word_t             rd_word;
    logic [SEL_W-1:0]  sel_idx;
    logic [LOW_W-1:0]  low_idx;

    assign sel_idx = addr[ADDR_W-1:LOW_W];
    assign low_idx = addr[LOW_W-1:0];

    sp_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .load_mode (load_mode),
        .load_addr (load_addr),
        .addr      (addr),
        .rise      (rise)
    );

    // Active-low write enable: strobe LOW in write mode only
    assign we_n = ~(wr_mode & ~strobe);

    // Decode the upper address bits into bank selects
    always_comb begin
        bank_sel = '0;
        bank_sel[sel_idx] = 1'b1;
    end

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            assign bank_we[b] = ~we_n & bank_sel[b];
            sp_bank #(.WORD_W(WORD_W), .DEPTH(BANK_DEPTH)) u_bank (
                .clk (clk),
                .we  (bank_we[b]),
                .a   (low_idx),
                .d   (din),
                .q   (bank_q[b])
            );
        end
    endgenerate

    assign rd_word = bank_q[sel_idx];

    sp_out_latch #(.WORD_W(WORD_W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .en_n  (strobe),
        .d     (rd_word),
        .q     (dout)
    );

    // R5
    no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |-> (bank_we == '0));
    // R7
    single_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
    // R4
    write_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (bank_we == '0));
endmodule

// File: tb/strobe_scratchpad_test.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
module strobe_scratchpad_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b1;
    logic       wr_mode = 1'b0;
    logic       load_mode = 1'b0;
    logic [5:0] load_addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;

    int compared = 0;
    int mismatched = 0;
    logic [3:0] mem_m [64];
    logic [5:0] addr_m = '0;

    typedef struct { logic [3:0] exp; string tag; } item_t;
    item_t q_exp [$];
    event sample_ev;
    bit done = 0;

    always #10 clk = ~clk;

    strobe_scratchpad uut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .wr_mode(wr_mode),
        .load_mode(load_mode), .load_addr(load_addr), .din(din), .dout(dout)
    );

    // Monitor: pop and compare on each sample request
    initial begin
        forever begin
            @(sample_ev);
            if (q_exp.size() != 0) begin
                item_t it;
                it = q_exp.pop_front();
                compared++;
                if (dout !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: dout=%0h expected=%0h", it.tag, dout, it.exp);
                end
            end
        end
    end

    task automatic push_check(input logic [3:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        q_exp.push_back(it);
        ->sample_ev;
        #1;
    endtask

    // One strobe cycle: nlow LOW cycles, then nhigh HIGH cycles, checked if chk
    task automatic strobe_cycle(input bit wr, input bit ld, input logic [5:0] la,
                                input logic [3:0] d, input int nlow, input int nhigh,
                                input bit chk, input string tag);
        logic [3:0] e;
        @(negedge clk);
        wr_mode = wr; load_mode = ld; load_addr = la; din = d; strobe = 1'b0;
        repeat (nlow) @(negedge clk);
        strobe = 1'b1;
        e = wr ? d : mem_m[addr_m];
        for (int k = 0; k < nhigh; k++) begin
            @(negedge clk);
            if (chk) push_check(e, tag);
        end
        if (wr) mem_m[addr_m] = d;
        addr_m = ld ? la : addr_m + 6'd1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_check(4'h0, "R1 reset output");

        // R4/R7: fill all 64 words in count mode, wrapping back to 0 (R2)
        for (int i = 0; i < 64; i++)
            strobe_cycle(1'b1, 1'b0, 6'd0, 4'((i * 7 + 3) & 15), 2, 1, (i < 3), "R4 write echo");
        // R2/R6/R7: read all words back, checking hold over two high cycles
        for (int i = 0; i < 64; i++)
            strobe_cycle(1'b0, 1'b0, 6'd0, 4'hF, 2, 2, 1'b1, "R2 R6 R7 read back");

        // R3: load address 37, then read it
        strobe_cycle(1'b0, 1'b1, 6'd37, 4'h0, 2, 1, 1'b1, "R3 read before load");
        strobe_cycle(1'b0, 1'b0, 6'd0, 4'h0, 2, 1, 1'b1, "R3 loaded word 37");

        // R5: read mode with strobe activity and new data writes nothing
        strobe_cycle(1'b0, 1'b1, 6'd21, 4'hA, 3, 1, 1'b1, "R5 read mode cycle");
        strobe_cycle(1'b0, 1'b1, 6'd20, 4'h5, 2, 1, 1'b1, "R5 word unchanged");

        // R7: same low bits in other banks stay independent
        strobe_cycle(1'b0, 1'b1, 6'd5,  4'h0, 2, 1, 1'b0, "R7 setup");
        strobe_cycle(1'b1, 1'b1, 6'd21, 4'hC, 2, 1, 1'b1, "R7 write bank0 word5");
        strobe_cycle(1'b0, 1'b1, 6'd53, 4'h0, 2, 1, 1'b1, "R7 bank1 word5 kept");
        strobe_cycle(1'b0, 1'b1, 6'd5,  4'h0, 2, 1, 1'b1, "R7 bank3 word5 kept");
        strobe_cycle(1'b0, 1'b0, 6'd0,  4'h0, 2, 1, 1'b1, "R7 bank0 word5 new");

        // R8: din changes inside the LOW phase; last value is stored
        strobe_cycle(1'b0, 1'b1, 6'd63, 4'h0, 2, 1, 1'b0, "R8 setup");
        @(negedge clk);
        wr_mode = 1'b1; load_mode = 1'b1; load_addr = 6'd63; din = 4'h1; strobe = 1'b0;
        @(negedge clk); din = 4'h2;
        @(negedge clk); din = 4'h9;
        @(negedge clk); strobe = 1'b1;
        mem_m[addr_m] = 4'h9; addr_m = 6'd63;
        @(negedge clk);
        strobe_cycle(1'b0, 1'b0, 6'd0, 4'h0, 2, 1, 1'b1, "R8 last din stored");
        // R2: 63 incremented to 0
        strobe_cycle(1'b0, 1'b0, 6'd0, 4'h0, 2, 1, 1'b1, "R2 wrap to word 0");

        // R1: reset mid-run returns the address to 0 and clears the output
        strobe_cycle(1'b0, 1'b1, 6'd40, 4'h0, 2, 1, 1'b0, "R1 setup");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; addr_m = 6'd0;
        push_check(4'h0, "R1 output cleared");
        strobe_cycle(1'b0, 1'b0, 6'd0, 4'h0, 2, 1, 1'b1, "R1 address zero");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule